// File: doc/BRIEF.md
# Charge Pump Gain Sequencer

This block chooses the gain of the charge pump that feeds a bank of LED current sinks. It has three gains: pass-through (1x), 1.5x and 2x. The pump starts at 1x. When a channel that is allowed to vote reports dropout, and the dropout holds for a qualification window, the gain moves up one step. The gain never moves down on its own. It goes back to 1x only on a set of system events: a register write over the serial port, the end of a downward brightness ramp, the end of a blink period, or a falling edge of the external enable pin while some channel outside enable-pin control is still lit.

A command register can force a fixed gain. While a force is active, the automatic logic is bypassed. Each entry into a boosted gain opens a soft-start interval, and the analog pump ramps its available current during that interval. The block also reports when the driver may shut down: no channel is lit and no force is active.

The qualification window and the soft-start length are counted in ticks. A prescaler derives the ticks from the block clock, and all three counts are parameters.

Top module: `pump_gain_sequencer`

## Requirements
- R1: In the cycle after synchronous reset, `mode` is 1x (code 00) and `soft_start` and `shutdown` are low.
- R2: `mode` is encoded as 00 = 1x, 01 = 1.5x and 10 = 2x. The code 11 never appears.
- R3: In automatic operation, each qualified dropout raises `mode` by exactly one step (1x to 1.5x, or 1.5x to 2x). At 2x, further qualified dropouts leave the mode at 2x.
- R4: A dropout qualifies only after a participating channel has reported dropout without a break for QUAL_TICKS ticks. Any cycle with no participating dropout restarts the count. The count also restarts on a mode change, a force, or a return-to-1x event.
- R5: Any of the following sets `mode` to 1x on the next edge: `reg_write`, `ramp_down_done` or `blink_end`. These events win over a dropout that qualifies in the same cycle.
- R6: A 1-to-0 transition of `en_pin` returns the mode to 1x only if some channel that is not under enable control has a nonzero code. Otherwise the transition leaves the mode unchanged.
- R7: A channel does not take part in dropout detection if any of these holds: its code is zero (`ch_zero`), it is in open-drain mode (`ch_odrain`), or it is under enable control (`ch_enctl`) while `en_pin` is low.
- R8: `cmd_force` bit 0 forces 1.5x, bit 1 forces 2x, and both bits together force 1x. While either bit is set, the forced gain holds and dropout has no effect.
- R9: Each change of `mode` into 1.5x or 2x raises `soft_start` for SS_TICKS ticks. A return to 1x clears it at once.
- R10: `shutdown` is high one cycle after a cycle in which no force is active and no channel is lit. A channel is lit when its code is nonzero and it is either not under enable control or `en_pin` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| dropout | input | N_CH | Per-channel dropout flags |
| ch_zero | input | N_CH | Channel code programmed to zero |
| ch_odrain | input | N_CH | Channel in open-drain output mode |
| ch_enctl | input | N_CH | Channel gated by the enable pin |
| en_pin | input | 1 | External enable, already synchronised |
| reg_write | input | 1 | Pulse: register update over serial port |
| ramp_down_done | input | 1 | Pulse: downward gradation finished |
| blink_end | input | 1 | Pulse: blink period ended |
| cmd_force | input | 2 | Force bits: [0] 1.5x, [1] 2x, both 1x |
| mode | output | 2 | Pump gain code |
| soft_start | output | 1 | Soft-start ramp active |
| shutdown | output | 1 | Driver may shut down |

## Verification
The bench builds the block with CLK_DIV = 2, QUAL_TICKS = 6 and SS_TICKS = 4. With these values a full qualification takes about a dozen cycles, so random stimulus often lets dropout persist long enough to climb both steps. It also often cuts a persistence run short just before the threshold. It lands return-to-1x events in the same cycle as a qualifying tick, and it makes soft-start intervals overlap or end early, all within a few thousand cycles. The divide of two keeps the tick phase visible in every window.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    typedef enum logic [1:0] {
        GAIN_1X  = 2'b00,
        GAIN_1P5 = 2'b01,
        GAIN_2X  = 2'b10
    } gain_e;

    // gain that a force pattern selects (bit0 = 1.5x, bit1 = 2x, both = 1x)
    function automatic gain_e force_gain(input logic [1:0] f);
        case (f)
            2'b01:   return GAIN_1P5;
            2'b10:   return GAIN_2X;
            default: return GAIN_1X;
        endcase
    endfunction

    // one step up, saturating at the top gain
    function automatic gain_e step_up(input gain_e g);
        case (g)
            GAIN_1X:  return GAIN_1P5;
            default:  return GAIN_2X;
        endcase
    endfunction

endpackage

// File: rtl/pgs_tick_gen.sv
module pgs_tick_gen #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            localparam int W = $clog2(DIV);
            logic [W-1:0] cnt;
            assign tick = (cnt == W'(DIV - 1));
            always_ff @(posedge clk) begin
                if (rst)       cnt <= '0;
                else if (tick) cnt <= '0;
                else           cnt <= cnt + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/pgs_dropout_qual.sv
module pgs_dropout_qual #(
    parameter int N_CH       = 9,
    parameter int QUAL_TICKS = 400
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            clr,
    input  logic [N_CH-1:0] dropout,
    input  logic [N_CH-1:0] ch_zero,
    input  logic [N_CH-1:0] ch_odrain,
    input  logic [N_CH-1:0] ch_enctl,
    input  logic            en_pin,
    output logic            fire
);
    localparam int CW = $clog2(QUAL_TICKS + 1);

    logic [N_CH-1:0] voter;
    logic            any_drop;
    logic [CW-1:0]   cnt;
    logic            at_end;

    // per-channel participation mask
    for (genvar i = 0; i < N_CH; i++) begin : g_vote
        assign voter[i] = dropout[i] & ~ch_zero[i] & ~ch_odrain[i]
                          & ~(ch_enctl[i] & ~en_pin);
    end

    assign any_drop = |voter;
    assign at_end   = (cnt == CW'(QUAL_TICKS - 1));
    assign fire     = any_drop & ~clr & tick & at_end;

    always_ff @(posedge clk) begin
        if (rst || clr || !any_drop) cnt <= '0;
        else if (tick)               cnt <= at_end ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/pgs_softstart.sv
module pgs_softstart #(
    parameter int SS_TICKS = 125
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic entry,
    input  logic to_base,
    output logic active
);
    localparam int SW = $clog2(SS_TICKS + 1);

    logic [SW-1:0] left;

    assign active = (left != '0);

    always_ff @(posedge clk) begin
        if (rst || to_base)        left <= '0;
        else if (entry)            left <= SW'(SS_TICKS);
        else if (tick && active)   left <= left - 1'b1;
    end
endmodule

// File: rtl/pump_gain_sequencer.sv
module pump_gain_sequencer
    import pgs_pkg::*;
#(
    parameter int N_CH       = 9,
    parameter int CLK_DIV    = 32,
    parameter int QUAL_TICKS = 400,
    parameter int SS_TICKS   = 125
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] dropout,
    input  logic [N_CH-1:0] ch_zero,
    input  logic [N_CH-1:0] ch_odrain,
    input  logic [N_CH-1:0] ch_enctl,
    input  logic            en_pin,
    input  logic            reg_write,
    input  logic            ramp_down_done,
    input  logic            blink_end,
    input  logic [1:0]      cmd_force,
    output logic [1:0]      mode,
    output logic            soft_start,
    output logic            shutdown
);
    gain_e gain_q, gain_d;
    logic  tick, fire, forced, back_to_1x;
    logic  en_prev, en_fall, others_lit, any_lit;
    logic  shut_q;

    pgs_tick_gen #(.DIV(CLK_DIV)) u_tick (
        .clk (clk), .rst (rst), .tick (tick)
    );

    assign forced     = |cmd_force;
    assign en_fall    = en_prev & ~en_pin;
    assign others_lit = |(~ch_zero & ~ch_enctl);
    assign any_lit    = |(~ch_zero & ~(ch_enctl & {N_CH{~en_pin}}));
    assign back_to_1x = reg_write | ramp_down_done | blink_end
                        | (en_fall & others_lit);

    pgs_dropout_qual #(.N_CH(N_CH), .QUAL_TICKS(QUAL_TICKS)) u_qual (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .clr       (forced | back_to_1x),
        .dropout   (dropout),
        .ch_zero   (ch_zero),
        .ch_odrain (ch_odrain),
        .ch_enctl  (ch_enctl),
        .en_pin    (en_pin),
        .fire      (fire)
    );

    always_comb begin
        gain_d = gain_q;
        if (forced)                        gain_d = force_gain(cmd_force);
        else if (back_to_1x)               gain_d = GAIN_1X;
        else if (fire && gain_q != GAIN_2X) gain_d = step_up(gain_q);
    end

    pgs_softstart #(.SS_TICKS(SS_TICKS)) u_ss (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .entry   (gain_d != GAIN_1X && gain_d != gain_q),
        .to_base (gain_d == GAIN_1X),
        .active  (soft_start)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_q  <= GAIN_1X;
            en_prev <= 1'b0;
            shut_q  <= 1'b0;
        end else begin
            gain_q  <= gain_d;
            en_prev <= en_pin;
            shut_q  <= ~forced & ~any_lit;
        end
    end

    assign mode     = gain_q;
    assign shutdown = shut_q;
endmodule

// File: rtl/pgs_checker.sv
module pgs_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] cmd_force,
    input logic       reg_write,
    input logic       ramp_down_done,
    input logic       blink_end,
    input logic [1:0] mode,
    input logic       soft_start,
    input logic       shutdown
);
    a_r2_legal_code: assert property (@(posedge clk) disable iff (rst)
        mode != 2'b11);

    a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
        ($past(cmd_force) == 2'b00 && $past(mode) == 2'b00) |-> mode != 2'b10);

    a_r5_event_to_base: assert property (@(posedge clk) disable iff (rst)
        ($past(cmd_force) == 2'b00
         && $past(reg_write | ramp_down_done | blink_end)) |-> mode == 2'b00);

    a_r8_both_forces_base: assert property (@(posedge clk) disable iff (rst)
        $past(cmd_force) == 2'b11 |-> mode == 2'b00);

    a_r9_ramp_only_boosted: assert property (@(posedge clk) disable iff (rst)
        soft_start |-> mode != 2'b00);

    a_r10_no_shut_forced: assert property (@(posedge clk) disable iff (rst)
        shutdown |-> $past(cmd_force) == 2'b00);
endmodule

bind pump_gain_sequencer pgs_checker u_pgs_chk (
    .clk            (clk),
    .rst            (rst),
    .cmd_force      (cmd_force),
    .reg_write      (reg_write),
    .ramp_down_done (ramp_down_done),
    .blink_end      (blink_end),
    .mode           (mode),
    .soft_start     (soft_start),
    .shutdown       (shutdown)
);

// File: tb/pump_gain_sequencer_bench.sv
module pump_gain_sequencer_bench;
    localparam int N  = 9;
    localparam int DV = 2;
    localparam int QT = 6;
    localparam int ST = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] dropout = '0, ch_zero = '0, ch_odrain = '0, ch_enctl = '0;
    logic en_pin = 1'b0, reg_write = 1'b0, ramp_down_done = 1'b0, blink_end = 1'b0;
    logic [1:0] cmd_force = 2'b00;
    logic [1:0] mode;
    logic soft_start, shutdown;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    string lbl = "R1";

    // reference state
    int m_div, m_cnt, m_mode, m_ss;
    bit m_shut, m_enprev;

    always #2 clk = ~clk;

    pump_gain_sequencer #(.N_CH(N), .CLK_DIV(DV), .QUAL_TICKS(QT), .SS_TICKS(ST))
    u_pump_gain_sequencer (
        .clk(clk), .rst(rst), .dropout(dropout), .ch_zero(ch_zero),
        .ch_odrain(ch_odrain), .ch_enctl(ch_enctl), .en_pin(en_pin),
        .reg_write(reg_write), .ramp_down_done(ramp_down_done),
        .blink_end(blink_end), .cmd_force(cmd_force),
        .mode(mode), .soft_start(soft_start), .shutdown(shutdown)
    );

    function automatic int forced_target(input logic [1:0] f);
        if (f == 2'b01) return 1;
        if (f == 2'b10) return 2;
        return 0;
    endfunction

    task automatic model_reset();
        m_div = 0; m_cnt = 0; m_mode = 0; m_ss = 0; m_shut = 0; m_enprev = 0;
    endtask

    task automatic model_step();
        bit tick, drop, lit, others, evt, forced, fire;
        int nm;
        logic [N-1:0] gate;
        tick   = (m_div == DV - 1);
        gate   = ch_enctl & {N{~en_pin}};
        drop   = |(dropout & ~ch_zero & ~ch_odrain & ~gate);
        lit    = |(~ch_zero & ~gate);
        others = |(~ch_zero & ~ch_enctl);
        evt    = reg_write | ramp_down_done | blink_end | (m_enprev & ~en_pin & others);
        forced = |cmd_force;
        fire   = drop && !forced && !evt && tick && (m_cnt == QT - 1);
        if (forced)                  nm = forced_target(cmd_force);
        else if (evt)                nm = 0;
        else if (fire && m_mode < 2) nm = m_mode + 1;
        else                         nm = m_mode;
        if (!drop || forced || evt)  m_cnt = 0;
        else if (tick)               m_cnt = (m_cnt == QT - 1) ? 0 : m_cnt + 1;
        if (nm == 0)                 m_ss = 0;
        else if (nm != m_mode)       m_ss = ST;
        else if (tick && m_ss != 0)  m_ss = m_ss - 1;
        m_shut   = !forced && !lit;
        m_enprev = en_pin;
        m_div    = tick ? 0 : m_div + 1;
        m_mode   = nm;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        if (rst) model_reset(); else model_step();
        @(negedge clk);
        chk({lbl, " mode"}, int'(mode), m_mode);
        chk({lbl, " soft_start"}, int'(soft_start), int'(m_ss != 0));
        chk({lbl, " shutdown"}, int'(shutdown), int'(m_shut));
        reg_write = 0; ramp_down_done = 0; blink_end = 0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        run(3);
        rst = 1'b0;
        lbl = "R1"; run(1);
        chk("R1 mode after reset", int'(mode), 0);
        chk("R1 soft_start after reset", int'(soft_start), 0);

        // R4: short dropout does nothing
        lbl = "R4"; dropout = 9'h001; run(QT * DV - 3);
        dropout = '0; run(2); dropout = 9'h001; run(QT * DV - 3);
        chk("R4 interrupted persistence", int'(mode), 0);
        dropout = '0; run(2);
        // R3: two full windows climb to 2x, then saturate
        lbl = "R3"; dropout = 9'h010; run(QT * DV + 2);
        chk("R3 first step 1.5x", int'(mode), 1);
        lbl = "R9";
        chk("R9 soft-start on entry", int'(soft_start), 1);
        lbl = "R3"; run(QT * DV + 2);
        chk("R3 second step 2x", int'(mode), 2);
        run(3 * QT * DV);
        chk("R3 saturate at 2x", int'(mode), 2);
        lbl = "R2";
        chk("R2 code not 11", int'(mode == 2'b11), 0);
        // R5
        lbl = "R5"; reg_write = 1; run(1);
        chk("R5 register write to 1x", int'(mode), 0);
        dropout = '0; run(2);
        // R7: zero-code and open-drain channels don't vote
        lbl = "R7"; ch_zero = 9'h004; ch_odrain = 9'h008; dropout = 9'h00C;
        run(3 * QT * DV);
        chk("R7 masked channels ignored", int'(mode), 0);
        ch_enctl = 9'h020; en_pin = 0; dropout = 9'h020; run(3 * QT * DV);
        chk("R7 enable-gated channel ignored", int'(mode), 0);
        dropout = '0; ch_zero = '0; ch_odrain = '0;
        // R6: enable falling edge, others lit -> 1x
        lbl = "R6"; en_pin = 1; cmd_force = 2'b10; run(2); cmd_force = 0; run(1);
        chk("R6 start at 2x", int'(mode), 2);
        en_pin = 0; run(1);
        chk("R6 fall with others lit", int'(mode), 0);
        ch_zero = 9'h1DF; en_pin = 1; cmd_force = 2'b01; run(2); cmd_force = 0; run(1);
        en_pin = 0; run(1);
        chk("R6 fall with nothing else lit", int'(mode), 1);
        // R10
        lbl = "R10"; run(1);
        chk("R10 shutdown when dark", int'(shutdown), 1);
        cmd_force = 2'b01; run(1);
        chk("R10 no shutdown when forced", int'(shutdown), 0);
        // R8
        lbl = "R8"; ch_zero = '0; ch_enctl = '0; dropout = 9'h1FF;
        cmd_force = 2'b11; run(4 * QT * DV);
        chk("R8 both bits force 1x", int'(mode), 0);
        cmd_force = 2'b10; run(1);
        chk("R8 force 2x", int'(mode), 2);
        cmd_force = 2'b01; run(1);
        chk("R8 force 1.5x", int'(mode), 1);
        cmd_force = 0; dropout = 0; reg_write = 1; run(2);

        // random phase
        lbl = "R3 R4 R5 R6 R7 R8 R9 R10 random";
        void'($urandom(32'd2024));
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 19) == 0) dropout = N'($urandom);
            if ($urandom_range(0, 39) == 0) ch_zero = N'($urandom) & N'($urandom);
            if ($urandom_range(0, 39) == 0) ch_odrain = N'($urandom) & N'($urandom) & N'($urandom);
            if ($urandom_range(0, 39) == 0) ch_enctl = N'($urandom) & N'($urandom);
            if ($urandom_range(0, 29) == 0) en_pin = ~en_pin;
            if ($urandom_range(0, 49) == 0)
                cmd_force = ($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'b00;
            reg_write      = ($urandom_range(0, 89) == 0);
            ramp_down_done = ($urandom_range(0, 89) == 0);
            blink_end      = ($urandom_range(0, 89) == 0);
            cyc();
        end
        finish_run();
    end
endmodule